// File: doc/BRIEF.md
# Blocking Neighbour Port Unit

This unit sits between a node's execution core and its four adjacent-node links (up, right, down, left). The core issues one transfer at a time: a direction code, a read/write flag and, for writes, a data word. The unit holds that request until the chosen link completes a valid/ready handshake. It then raises a one-cycle completion pulse that carries the received word and the direction that was used.

Two pseudo-ports sit on top of the four physical links. "Any" offers the transfer on every installed link at once and completes on exactly one of them. If several neighbours are able in the same cycle, a fixed priority picks the winner. "Last" replays the direction of the most recent completed transfer. Each link has a presence input. A slot with no neighbour installed is electrically silent, so an access aimed only at it blocks forever.

Top module: `nbr_port_unit`

## Requirements
- R1: After reset, `done` is low, all `rx_ready` and `tx_valid` outputs are low, and no direction is recorded as the last one used.
- R2: A read with a fixed code (0 up, 1 right, 2 down, 3 left) raises `rx_ready` only on that direction. It completes on that link's handshake, and in the next cycle `done` is high with `done_rdata` equal to that link's word and `done_dir` equal to the code.
- R3: A write with a fixed code raises `tx_valid` only on that direction. The request's word appears on `tx_data` and stays unchanged until the neighbour accepts it. `done_rdata` is zero on write completions.
- R4: An access blocks with `done` low for as long as the selected link's partner signal (`rx_valid` for reads, `tx_ready` for writes) stays low, and it completes once that signal rises.
- R5: Code 4 (any) completes on exactly one link: the lowest-numbered able direction, with up(0) > right(1) > down(2) > left(3). No other link sees a handshake.
- R6: Code 5 (last) addresses the direction reported in `done_dir` of the most recent completion. Every completion updates it.
- R7: Code 5 before any completion since reset, and codes 6 and 7 at any time, never complete and raise no `rx_ready` or `tx_valid`.
- R8: When `link_present[i]` is low, `rx_ready[i]` and `tx_valid[i]` stay low and `rx_valid[i]`/`tx_ready[i]` are ignored. Under code 4 the transfer goes to the best present link.
- R9: `done` is a single-cycle pulse. `req_valid` is taken only when the unit is idle, and a request raised while a transfer is pending has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Core issues a transfer (sampled when idle) |
| req_write | input | 1 | 1 = write to neighbour, 0 = read from neighbour |
| req_port | input | 3 | Direction code: 0 up, 1 right, 2 down, 3 left, 4 any, 5 last |
| req_wdata | input | DATA_W | Word to send on writes |
| done | output | 1 | One-cycle completion pulse |
| done_rdata | output | DATA_W | Received word (zero for writes) |
| done_dir | output | 2 | Direction that completed |
| link_present | input | 4 | Per-direction neighbour installed |
| rx_valid | input | 4 | Neighbour offers a word |
| rx_ready | output | 4 | Unit takes the offered word |
| rx_data | input | 4*DATA_W | Incoming words, lane i at bits [i*DATA_W +: DATA_W] |
| tx_valid | output | 4 | Unit offers a word |
| tx_ready | input | 4 | Neighbour accepts the word |
| tx_data | output | 4*DATA_W | Outgoing word, same on every lane |

## Verification
Fixed-direction reads and writes are swept over every combination of able neighbours that includes the target. This shows that the unit ignores the other links rather than merely preferring the target. Code 4 is run over all fifteen non-empty patterns of able links in both directions of transfer, so each priority pairing is covered. Presence masks with one link removed tell the two cases apart: gating of the absent slot, and ordinary priority among the remaining links. Delayed partner signals, and requests poked in during a pending transfer, show blocking and the idle-only acceptance of requests. Code 5 is compared against each previous completion, and against the stall after reset.

// File: rtl/nbr_pkg.sv
package nbr_pkg;
  localparam int NDIR   = 4;
  localparam int DIR_W  = 2;
  localparam int CODE_W = 3;

  localparam logic [CODE_W-1:0] CODE_ANY  = 3'd4;
  localparam logic [CODE_W-1:0] CODE_LAST = 3'd5;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_DONE = 2'd2
  } xfer_state_e;
endpackage

// File: rtl/nbr_rst_sync.sv
module nbr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/nbr_port_decode.sv
module nbr_port_decode
  import nbr_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  input  logic              last_vld_i,
  input  logic [DIR_W-1:0]  last_dir_i,
  output logic [NDIR-1:0]   sel_o
);
  logic is_any;
  logic is_last;

  assign is_any  = (code_i == CODE_ANY);
  assign is_last = (code_i == CODE_LAST) && last_vld_i;

  for (genvar g = 0; g < NDIR; g++) begin : g_dir
    assign sel_o[g] = (code_i == CODE_W'(g)) || is_any ||
                      (is_last && (last_dir_i == DIR_W'(g)));
  end
endmodule

// File: rtl/nbr_port_arbiter.sv
module nbr_port_arbiter #(
  parameter int N = 4
) (
  input  logic [N-1:0] cand_i,
  output logic [N-1:0] grant_o,
  output logic [N-1:0] ahead_o
);
  // ahead_o[i]: some lower-numbered (higher priority) candidate exists
  assign ahead_o[0] = 1'b0;
  for (genvar g = 1; g < N; g++) begin : g_chain
    assign ahead_o[g] = ahead_o[g-1] | cand_i[g-1];
  end

  for (genvar g = 0; g < N; g++) begin : g_grant
    assign grant_o[g] = cand_i[g] & ~ahead_o[g];
  end
endmodule

// File: rtl/nbr_port_unit.sv
module nbr_port_unit
  import nbr_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 arst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [2:0]           req_port,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic                 done,
  output logic [DATA_W-1:0]    done_rdata,
  output logic [1:0]           done_dir,
  input  logic [3:0]           link_present,
  input  logic [3:0]           rx_valid,
  output logic [3:0]           rx_ready,
  input  logic [4*DATA_W-1:0]  rx_data,
  output logic [3:0]           tx_valid,
  input  logic [3:0]           tx_ready,
  output logic [4*DATA_W-1:0]  tx_data
);
  localparam int LANES_W = NDIR * DATA_W;

  logic rst_n;

  nbr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk       (clk),
    .arst_n    (arst_n),
    .rst_n_sync(rst_n)
  );

  xfer_state_e         state_q, state_d;
  logic                wr_q;
  logic [CODE_W-1:0]   code_q;
  logic [DATA_W-1:0]   wdata_q;
  logic                last_vld_q;
  logic [DIR_W-1:0]    last_dir_q;
  logic [DATA_W-1:0]   rdata_q, rdata_d;
  logic [DIR_W-1:0]    dir_q;

  logic [NDIR-1:0]     sel, sel_live, cand, grant, ahead;
  logic [NDIR-1:0]     rx_ok, tx_ok;
  logic                active, fire, load_en, cap_en;
  logic [DIR_W-1:0]    grant_idx;

  nbr_port_decode u_dec (
    .code_i    (code_q),
    .last_vld_i(last_vld_q),
    .last_dir_i(last_dir_q),
    .sel_o     (sel)
  );

  assign active   = (state_q == ST_BUSY);
  assign sel_live = sel & link_present & {NDIR{active}};
  assign rx_ok    = rx_valid & link_present;
  assign tx_ok    = tx_ready & link_present;
  assign cand     = sel_live & (wr_q ? tx_ok : rx_ok);

  nbr_port_arbiter #(.N(NDIR)) u_arb (
    .cand_i (cand),
    .grant_o(grant),
    .ahead_o(ahead)
  );

  // Link outputs: reads accept only the winner; writes withdraw valid
  // from any link outranked by an able higher-priority link.
  for (genvar g = 0; g < NDIR; g++) begin : g_link
    assign rx_ready[g] = ~wr_q & grant[g];
    assign tx_valid[g] =  wr_q & sel_live[g] & ~ahead[g];
    assign tx_data[g*DATA_W +: DATA_W] = wdata_q;
  end

  assign fire = |grant;

  always_comb begin
    grant_idx = '0;
    for (int i = NDIR - 1; i >= 0; i--) begin
      if (grant[i]) grant_idx = DIR_W'(i);
    end
  end

  always_comb begin
    rdata_d = '0;
    if (!wr_q) rdata_d = rx_data[grant_idx*DATA_W +: DATA_W];
  end

  assign load_en = (state_q == ST_IDLE) && req_valid;
  assign cap_en  = active && fire;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_valid) state_d = ST_BUSY;
      ST_BUSY: if (fire)      state_d = ST_DONE;
      ST_DONE:                state_d = ST_IDLE;
      default:                state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      code_q  <= '0;
      wdata_q <= '0;
    end else if (load_en) begin
      wr_q    <= req_write;
      code_q  <= req_port;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_vld_q <= 1'b0;
      last_dir_q <= '0;
      rdata_q    <= '0;
      dir_q      <= '0;
    end else if (cap_en) begin
      last_vld_q <= 1'b1;
      last_dir_q <= grant_idx;
      rdata_q    <= rdata_d;
      dir_q      <= grant_idx;
    end
  end

  assign done       = (state_q == ST_DONE);
  assign done_rdata = rdata_q;
  assign done_dir   = dir_q;

  // ---------------- assertions ----------------
  a_r5_single_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(((rx_valid & rx_ready) | (tx_valid & tx_ready)) & link_present));

  a_r8_absent_silent: assert property (@(posedge clk) disable iff (!rst_n)
    ((rx_ready | tx_valid) & ~link_present) == 4'b0);

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_last_matches_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (last_vld_q && (last_dir_q == done_dir)));

  a_r3_tx_word_held: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !fire) |=> $stable(tx_data));

  a_r7_last_unset_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (active && code_q == CODE_LAST && !last_vld_q) |=> (state_q == ST_BUSY));

  a_r9_busy_ignores_req: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !fire) |=> ($stable(code_q) && $stable(wr_q)));
endmodule

// File: tb/nbr_port_unit_tb.sv
module nbr_port_unit_tb_top;
  localparam int W = 8;

  logic           clk = 1'b0;
  logic           arst_n;
  logic           req_valid, req_write;
  logic [2:0]     req_port;
  logic [W-1:0]   req_wdata;
  logic           done;
  logic [W-1:0]   done_rdata;
  logic [1:0]     done_dir;
  logic [3:0]     link_present, rx_valid, rx_ready, tx_valid, tx_ready;
  logic [4*W-1:0] rx_data, tx_data;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  nbr_port_unit #(.DATA_W(W)) dut_i (
    .clk(clk), .arst_n(arst_n),
    .req_valid(req_valid), .req_write(req_write), .req_port(req_port),
    .req_wdata(req_wdata),
    .done(done), .done_rdata(done_rdata), .done_dir(done_dir),
    .link_present(link_present),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data)
  );

  function automatic logic [W-1:0] lane_word(input int d, input int seed);
    return W'((d + 1) * 16 + seed);
  endfunction

  function automatic int low_bit(input logic [3:0] m);
    for (int i = 0; i < 4; i++) if (m[i]) return i;
    return -1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    arst_n = 1'b0;
    req_valid = 0; req_write = 0; req_port = 0; req_wdata = 0;
    link_present = 4'hF; rx_valid = 0; tx_ready = 0; rx_data = 0;
    repeat (2) @(negedge clk);
    arst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // One transfer. Partner signals come up after dly cycles; with poke, a
  // competing request and foreign partner signals are raised meanwhile.
  task automatic run_op(input bit wr, input logic [2:0] code, input logic [W-1:0] wd,
                        input logic [3:0] pres, input logic [3:0] offer,
                        input int dly, input bit poke, input int maxw, input int seed,
                        output bit got, output int gdir, output int grd,
                        output int nfire, output logic [3:0] fmask,
                        output bit early, output bit pulse_ok, output bit txok);
    logic [3:0] f;
    got = 0; gdir = -1; grd = -1; nfire = 0; fmask = 0;
    early = 0; pulse_ok = 1; txok = 1;
    for (int i = 0; i < 4; i++) rx_data[i*W +: W] = lane_word(i, seed);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_port = code; req_wdata = wd;
    link_present = pres; rx_valid = 0; tx_ready = 0;
    @(negedge clk);
    req_valid = 0;
    for (int c = 0; c < dly; c++) begin
      if (poke) begin
        req_valid = 1; req_port = 3'd0; req_write = ~wr;
        rx_valid = pres & ~offer; tx_ready = pres & ~offer;
      end
      #4;
      f = (rx_valid & rx_ready) | (tx_valid & tx_ready);
      nfire += $countones(f); fmask |= f;
      @(negedge clk);
      if (done) early = 1;
    end
    req_valid = 0; req_write = wr; req_port = code;
    rx_valid = wr ? 4'b0 : offer;
    tx_ready = wr ? offer : 4'b0;
    for (int c = 0; c < maxw && !got; c++) begin
      #4;
      f = (rx_valid & rx_ready) | (tx_valid & tx_ready);
      nfire += $countones(f); fmask |= f;
      for (int i = 0; i < 4; i++)
        if (f[i] && tx_valid[i] && tx_data[i*W +: W] != wd) txok = 0;
      @(negedge clk);
      if (done) begin got = 1; gdir = int'(done_dir); grd = int'(done_rdata); end
    end
    rx_valid = 0; tx_ready = 0;
    if (got) begin
      @(negedge clk);
      if (done) pulse_ok = 0;
    end
  endtask

  bit got, early, pok, txok;
  int gdir, grd, nfire;
  logic [3:0] fmask;

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL R9 watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    do_reset();
    // R1: reset state
    #1;
    chk(done == 0, "R1 done after reset", int'(done), 0);
    chk(rx_ready == 0 && tx_valid == 0, "R1 link outputs after reset",
        int'({rx_ready, tx_valid}), 0);
    // R1/R7: last before any transfer stalls
    run_op(0, 3'd5, 0, 4'hF, 4'hF, 0, 0, 10, 0, got, gdir, grd, nfire, fmask, early, pok, txok);
    chk(!got && nfire == 0, "R7 last unset stalls", nfire + int'(got), 0);
    do_reset();
    for (int code = 6; code < 8; code++) begin
      run_op(code[0], 3'(code), 8'h5A, 4'hF, 4'hF, 0, 0, 10, 0,
             got, gdir, grd, nfire, fmask, early, pok, txok);
      chk(!got && nfire == 0, "R7 reserved code stalls", nfire + int'(got), 0);
      do_reset();
    end

    // R2/R3: fixed directions, every able pattern that includes the target
    for (int d = 0; d < 4; d++) begin
      for (int m = 1; m < 16; m++) begin
        if (m[d]) begin
          for (int wr = 0; wr < 2; wr++) begin
            run_op(wr[0], 3'(d), W'(m * 7 + d), 4'hF, 4'(m), 0, 0, 6, m,
                   got, gdir, grd, nfire, fmask, early, pok, txok);
            chk(got && gdir == d, wr ? "R3 write dir" : "R2 read dir", gdir, d);
            chk(nfire == 1 && fmask == 4'(1 << d), wr ? "R3 only target" : "R2 only target",
                int'(fmask), 1 << d);
            if (wr) begin
              chk(txok && grd == 0, "R3 write word and zero rdata", grd, 0);
            end else begin
              chk(grd == int'(lane_word(d, m)), "R2 read data", grd, int'(lane_word(d, m)));
            end
            chk(pok, "R9 done single cycle", int'(pok), 1);
          end
        end
      end
      // R6: last replays the direction just used
      run_op(0, 3'd5, 0, 4'hF, 4'hF, 0, 0, 6, 3, got, gdir, grd, nfire, fmask, early, pok, txok);
      chk(got && gdir == d && fmask == 4'(1 << d), "R6 last follows previous", gdir, d);
    end

    // R5: any over all non-empty able patterns, both transfer kinds
    for (int m = 1; m < 16; m++) begin
      for (int wr = 0; wr < 2; wr++) begin
        run_op(wr[0], 3'd4, W'(m), 4'hF, 4'(m), 0, 0, 6, m,
               got, gdir, grd, nfire, fmask, early, pok, txok);
        chk(got && gdir == low_bit(4'(m)) && nfire == 1, "R5 any priority", gdir, low_bit(4'(m)));
        if (!wr) chk(grd == int'(lane_word(low_bit(4'(m)), m)), "R5 any read data",
                     grd, int'(lane_word(low_bit(4'(m)), m)));
        run_op(1, 3'd5, 8'h33, 4'hF, 4'hF, 0, 0, 6, 0,
               got, gdir, grd, nfire, fmask, early, pok, txok);
        chk(got && gdir == low_bit(4'(m)), "R6 last after any", gdir, low_bit(4'(m)));
      end
    end

    // R4: blocking for several delays
    for (int dly = 1; dly < 5; dly++) begin
      run_op(dly[0], 3'(dly % 4), 8'hC3, 4'hF, 4'(1 << (dly % 4)), dly, 0, 6, dly,
             got, gdir, grd, nfire, fmask, early, pok, txok);
      chk(!early && got && gdir == dly % 4, "R4 blocks until partner", int'(early), 0);
    end

    // R9: requests and foreign partners during a pending transfer are ignored
    run_op(0, 3'd2, 0, 4'hF, 4'b0100, 3, 1, 6, 9, got, gdir, grd, nfire, fmask, early, pok, txok);
    chk(!early && got && gdir == 2 && nfire == 1, "R9 busy ignores request", gdir, 2);
    chk(grd == int'(lane_word(2, 9)), "R9 pending read data", grd, int'(lane_word(2, 9)));

    // R8: absent slots under any, both kinds
    for (int k = 0; k < 4; k++) begin
      for (int wr = 0; wr < 2; wr++) begin
        run_op(wr[0], 3'd4, 8'h11, 4'(~(1 << k)), 4'hF, 0, 0, 6, k,
               got, gdir, grd, nfire, fmask, early, pok, txok);
        chk(got && gdir == low_bit(4'(~(1 << k))) && fmask[k] == 0, "R8 any skips absent",
            gdir, low_bit(4'(~(1 << k))));
      end
    end
    // R8: fixed access to absent slot stalls and stays silent
    for (int k = 0; k < 4; k++) begin
      run_op(k[0], 3'(k), 8'h22, 4'(~(1 << k)), 4'hF, 0, 0, 8, k,
             got, gdir, grd, nfire, fmask, early, pok, txok);
      chk(!got && nfire == 0, "R8 absent fixed stalls", nfire, 0);
      #4;
      chk(rx_ready == 0 && tx_valid == 0, "R8 absent link outputs low",
          int'({rx_ready, tx_valid}), 0);
      do_reset();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule